// File: doc/BRIEF.md
# Debug Halt Breakpoint Controller

This block sits beside a CPU core and decides when the core must stop running user code and enter a background (halted) debug state. It holds two private registers that only the serial debug port can reach, and neither appears in the CPU memory map. The first is an 8-bit control/status word. The second is a breakpoint address register whose width is set by a parameter (16 bits by default). A single comparator watches the CPU address bus against the breakpoint address. A control bit chooses how a match is used:

- **Forced stop:** the match is remembered and the core is halted at the next instruction boundary.
- **Opcode marking:** the opcode fetched from the matching address is marked, and the halt happens only if that marked opcode actually starts executing. A change of flow that throws the opcode away clears the mark.

The debug port can also request a halt directly, and it can release the core. The block keeps three sticky status flags, which are cleared when the debug port reads the status word:

- the core was seen in a low-power wait/stop state;
- a debug memory access was refused because of wait/stop;
- a debug memory access was refused because a slow bus access was still in progress.

Top module: `dbg_halt_ctl`

## Requirements
- R1: Under reset, and on the first cycle after it, `halt_req` is 0 and the breakpoint register is 0. The status word is {boot,boot,0,0,boot,0,0,0}, where boot is `boot_bgnd` sampled during reset, listed from bit 7 down to bit 0.
- R2: A control write (`dp_wr_ctl`) loads bits 7 (debug enable), 5 (breakpoint enable), 4 (mode: 1 = forced stop, 0 = opcode marking) and 3 (clock select) from `dp_wdata[7:0]`. Bits 6, 2, 1 and 0 are not changed by the write data.
- R3: A breakpoint write (`dp_wr_bkpt`) loads all of `dp_wdata` into the breakpoint register. The new value is visible on `dp_bkpt` in the next cycle.
- R4: Forced-stop mode (bits 7, 5 and 4 all 1): a cycle with `cpu_bus_vld` and `cpu_addr` equal to the breakpoint arms a stop. The first later cycle with `cpu_ibound` produces a `halt_req` that lasts exactly one cycle, and bit 6 (active) is 1 from that cycle onward.
- R5: Opcode-marking mode (bits 7 and 5 are 1, bit 4 is 0): a `cpu_fetch` at the breakpoint address marks the opcode. A following `cpu_exec` then gives a one-cycle `halt_req`. Executing an opcode fetched from any other address gives no halt.
- R6: A pending mark is dropped by `cpu_flush`, and it is also replaced by any later fetch from a non-matching address. After either event, `cpu_exec` causes no halt.
- R7: While bit 5 is 0, address matches cause no halt in either mode.
- R8: While bit 7 is 0, neither a breakpoint nor `dp_bgnd_cmd` causes a halt. With bit 7 set and the core not halted, `dp_bgnd_cmd` gives `halt_req` in the next cycle.
- R9: While bit 6 is 1, no new `halt_req` is produced. `dp_go` clears bit 6.
- R10: Bits 2 to 0 are sticky and are cleared by a status read (`dp_rd_stat`). If a setting event occurs in the same cycle as the read, the bit stays set. Bit 2 is set by any cycle with `cpu_wait_stop` high.
- R11: A debug memory command (`dp_mem_cmd`) issued while `cpu_wait_stop` is high sets bit 1. Otherwise, if `cpu_slow_busy` is high, it sets bit 0. Only one of the two bits is set by a given command.
- R12: Bit 3 (clock select) resets to 0 after a normal reset and to 1 after a reset with `boot_bgnd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_bgnd | input | 1 | Reset is into background mode (sampled during reset) |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_bus_vld | input | 1 | Bus access valid this cycle |
| cpu_fetch | input | 1 | Opcode fetch at cpu_addr |
| cpu_exec | input | 1 | Most recently fetched opcode starts executing |
| cpu_flush | input | 1 | Change of flow discards fetched opcode |
| cpu_ibound | input | 1 | Instruction boundary |
| cpu_wait_stop | input | 1 | Core is in wait or stop state |
| cpu_slow_busy | input | 1 | Slow bus access in progress |
| dp_wr_ctl | input | 1 | Debug port writes control bits |
| dp_rd_stat | input | 1 | Debug port reads status (clears bits 2..0) |
| dp_wr_bkpt | input | 1 | Debug port writes breakpoint address |
| dp_bgnd_cmd | input | 1 | Debug port halt request |
| dp_go | input | 1 | Debug port release from halt |
| dp_mem_cmd | input | 1 | Debug port memory access command |
| dp_wdata | input | ADDR_W | Debug port write data |
| dp_stat | output | 8 | Control/status word |
| dp_bkpt | output | ADDR_W | Breakpoint address |
| halt_req | output | 1 | One-cycle halt request to the core |

## Verification
The hardest condition to reach from the ports is a marked opcode that is either executed or discarded while other events land in the same cycle. Examples are a fetch and an execute together, a flush together with an execute, or a mode change while a stop is armed. Fixed sequences tend to keep these events apart. The stimulus therefore biases the address toward the breakpoint value and its neighbour, and fires the fetch, execute, flush and boundary strobes independently at high rates over hundreds of cycles. A bench model, built from the requirements, predicts the status word and `halt_req` on every cycle. Directed sequences cover the ordered cases: forced stop, mark and execute, mark then flush, mark replaced by a later fetch, and reads that collide with setting events.

// File: rtl/dbgc_pkg.sv
// Package: bit positions of the debug control/status word and the mode
// view passed between the submodules of dbg_halt_ctl.
package dbgc_pkg;
    localparam int STAT_W  = 8;
    localparam int B_EN    = 7;   // debug enable
    localparam int B_ACT   = 6;   // halted (read only)
    localparam int B_BKEN  = 5;   // breakpoint enable
    localparam int B_FORCE = 4;   // 1 forced stop, 0 opcode marking
    localparam int B_CLK   = 3;   // debug clock select
    localparam int B_WS    = 2;   // wait/stop seen (sticky)
    localparam int B_WSF   = 1;   // access refused: wait/stop (sticky)
    localparam int B_DVF   = 0;   // access refused: slow access (sticky)

    typedef struct packed {
        logic en;
        logic act;
        logic bken;
        logic force_m;
    } dbg_mode_t;
endpackage

// File: rtl/dbgc_addr_cmp.sv
// Breakpoint address register and equality comparator.
// Assumes: the register is written only through the debug port strobe;
// the match output is purely combinational on the current address.
module dbgc_addr_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] bkpt_q,
    output logic              match
);
    logic [ADDR_W-1:0] bit_eq;

    // Hold the breakpoint address; loaded by the debug port.
    always_ff @(posedge clk) begin
        if (!rst_n)  bkpt_q <= '0;
        else if (wr) bkpt_q <= wdata;
    end

    // Per-bit equality, one cell per address bit.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_eq
        assign bit_eq[i] = ~(addr[i] ^ bkpt_q[i]);
    end

    // Reduce to a single match flag.
    always_comb match = &bit_eq;
endmodule

// File: rtl/dbgc_trigger.sv
// Halt decision: keeps the armed forced-stop flag and the opcode mark,
// and issues a registered one-cycle halt request.
// Assumes: cpu_exec refers to the most recently fetched opcode; a fetch and
// an exec in one cycle means the old opcode executes and a new one arrives.
module dbgc_trigger
    import dbgc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dbg_mode_t mode,
    input  logic      match,
    input  logic      bus_vld,
    input  logic      fetch,
    input  logic      exec,
    input  logic      flush,
    input  logic      ibound,
    input  logic      bgnd_cmd,
    output logic      halt_now,
    output logic      halt_req
);
    logic force_pend, tag_pend;
    logic can_halt, force_fire, tag_fire, bgnd_fire;
    logic force_on, tag_on;

    // Which breakpoint behaviour is live this cycle.
    always_comb begin
        force_on = mode.bken & mode.force_m;
        tag_on   = mode.bken & ~mode.force_m;
    end

    // Candidate halt sources, all blocked while halted or disabled.
    always_comb begin
        can_halt   = mode.en & ~mode.act;
        bgnd_fire  = can_halt & bgnd_cmd;
        force_fire = can_halt & force_on & force_pend & ibound;
        tag_fire   = can_halt & tag_on & tag_pend & exec & ~flush;
        halt_now   = bgnd_fire | force_fire | tag_fire;
    end

    // Arm a forced stop on a matching bus access; drop it once a halt occurs.
    always_ff @(posedge clk) begin
        if (!rst_n)                   force_pend <= 1'b0;
        else if (!force_on || halt_now) force_pend <= 1'b0;
        else if (bus_vld && match)    force_pend <= 1'b1;
    end

    // Track the mark on the latest fetched opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  tag_pend <= 1'b0;
        else if (flush || !tag_on || halt_now)       tag_pend <= 1'b0;
        else if (fetch)                              tag_pend <= match;
        else if (exec)                               tag_pend <= 1'b0;
    end

    // Register the halt request towards the core.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_req <= 1'b0;
        else        halt_req <= halt_now;
    end
endmodule

// File: rtl/dbgc_ctl_stat.sv
// Control/status word: writable control bits, halted flag and three sticky
// status flags cleared on a debug-port read (a same-cycle set wins).
// Assumes: only the low eight bits of the write data carry control.
module dbgc_ctl_stat
    import dbgc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_bgnd,
    input  logic              wr_ctl,
    input  logic [STAT_W-1:0] wdata,
    input  logic              rd_stat,
    input  logic              go,
    input  logic              halt_now,
    input  logic              wait_stop,
    input  logic              mem_cmd,
    input  logic              slow_busy,
    output logic [STAT_W-1:0] stat,
    output dbg_mode_t         mode
);
    logic en_q, act_q, bken_q, force_q, clk_q, ws_q, wsf_q, dvf_q;
    logic set_ws, set_wsf, set_dvf;

    // Events that set the sticky flags this cycle.
    always_comb begin
        set_ws  = wait_stop;
        set_wsf = mem_cmd & wait_stop;
        set_dvf = mem_cmd & ~wait_stop & slow_busy;
    end

    // Writable control bits; reset values depend on the boot condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= boot_bgnd;
            bken_q  <= 1'b0;
            force_q <= 1'b0;
            clk_q   <= boot_bgnd;
        end else if (wr_ctl) begin
            en_q    <= wdata[B_EN];
            bken_q  <= wdata[B_BKEN];
            force_q <= wdata[B_FORCE];
            clk_q   <= wdata[B_CLK];
        end
    end

    // Halted flag: set by a halt, cleared by release.
    always_ff @(posedge clk) begin
        if (!rst_n)        act_q <= boot_bgnd;
        else if (halt_now) act_q <= 1'b1;
        else if (go)       act_q <= 1'b0;
    end

    // Sticky status flags with clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q  <= 1'b0;
            wsf_q <= 1'b0;
            dvf_q <= 1'b0;
        end else begin
            ws_q  <= set_ws  | (ws_q  & ~rd_stat);
            wsf_q <= set_wsf | (wsf_q & ~rd_stat);
            dvf_q <= set_dvf | (dvf_q & ~rd_stat);
        end
    end

    // Assemble the word and the mode view.
    always_comb begin
        stat          = '0;
        stat[B_EN]    = en_q;
        stat[B_ACT]   = act_q;
        stat[B_BKEN]  = bken_q;
        stat[B_FORCE] = force_q;
        stat[B_CLK]   = clk_q;
        stat[B_WS]    = ws_q;
        stat[B_WSF]   = wsf_q;
        stat[B_DVF]   = dvf_q;
        mode.en       = en_q;
        mode.act      = act_q;
        mode.bken     = bken_q;
        mode.force_m  = force_q;
    end
endmodule

// File: rtl/dbg_halt_ctl.sv
// Top: debug halt breakpoint controller. Connects the breakpoint comparator,
// the halt decision and the control/status word.
// Assumes ADDR_W >= 8 so the control write fits in the low data byte.
module dbg_halt_ctl
    import dbgc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_bgnd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_bus_vld,
    input  logic              cpu_fetch,
    input  logic              cpu_exec,
    input  logic              cpu_flush,
    input  logic              cpu_ibound,
    input  logic              cpu_wait_stop,
    input  logic              cpu_slow_busy,
    input  logic              dp_wr_ctl,
    input  logic              dp_rd_stat,
    input  logic              dp_wr_bkpt,
    input  logic              dp_bgnd_cmd,
    input  logic              dp_go,
    input  logic              dp_mem_cmd,
    input  logic [ADDR_W-1:0] dp_wdata,
    output logic [STAT_W-1:0] dp_stat,
    output logic [ADDR_W-1:0] dp_bkpt,
    output logic              halt_req
);
    dbg_mode_t mode;
    logic      match;
    logic      halt_now;

    dbgc_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (dp_wr_bkpt),
        .wdata  (dp_wdata),
        .addr   (cpu_addr),
        .bkpt_q (dp_bkpt),
        .match  (match)
    );

    dbgc_trigger u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .match    (match),
        .bus_vld  (cpu_bus_vld),
        .fetch    (cpu_fetch),
        .exec     (cpu_exec),
        .flush    (cpu_flush),
        .ibound   (cpu_ibound),
        .bgnd_cmd (dp_bgnd_cmd),
        .halt_now (halt_now),
        .halt_req (halt_req)
    );

    dbgc_ctl_stat u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_bgnd (boot_bgnd),
        .wr_ctl    (dp_wr_ctl),
        .wdata     (dp_wdata[STAT_W-1:0]),
        .rd_stat   (dp_rd_stat),
        .go        (dp_go),
        .halt_now  (halt_now),
        .wait_stop (cpu_wait_stop),
        .mem_cmd   (dp_mem_cmd),
        .slow_busy (cpu_slow_busy),
        .stat      (dp_stat),
        .mode      (mode)
    );
endmodule

// File: rtl/dbg_halt_ctl_chk.sv
// Checker for dbg_halt_ctl: port-level temporal properties, bound below.
module dbg_halt_ctl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wait_stop,
    input logic              dp_wr_ctl,
    input logic              dp_rd_stat,
    input logic              dp_wr_bkpt,
    input logic              dp_bgnd_cmd,
    input logic              dp_mem_cmd,
    input logic [ADDR_W-1:0] dp_wdata,
    input logic [7:0]        dp_stat,
    input logic [ADDR_W-1:0] dp_bkpt,
    input logic              halt_req
);
    // R4: a halt request lasts one cycle
    a_r4_halt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !halt_req);

    // R9: halted flag is up whenever a request is issued
    a_r9_act_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> dp_stat[6]);

    // R8: no halt unless debug enable was set
    a_r8_halt_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && halt_req |-> $past(dp_stat[7]));

    // R7: a breakpoint halt needs the breakpoint enable
    a_r7_bp_needs_bken: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && halt_req && !$past(dp_bgnd_cmd) |-> $past(dp_stat[5]));

    // R2: control write lands in the writable bits
    a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dp_wr_ctl) |->
            dp_stat[7] == $past(dp_wdata[7]) && dp_stat[5:3] == $past(dp_wdata[5:3]));

    // R3: breakpoint write lands in the register
    a_r3_bkpt_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dp_wr_bkpt) |-> dp_bkpt == $past(dp_wdata));

    // R10: a read with no setting event clears the sticky flags
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dp_rd_stat) && !$past(cpu_wait_stop) && !$past(dp_mem_cmd)
            |-> dp_stat[2:0] == 3'b000);

    // R11: refused access during wait/stop sets bit 1
    a_r11_wsf_set: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(dp_mem_cmd) && $past(cpu_wait_stop) |-> dp_stat[1]);
endmodule

bind dbg_halt_ctl dbg_halt_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wait_stop (cpu_wait_stop),
    .dp_wr_ctl     (dp_wr_ctl),
    .dp_rd_stat    (dp_rd_stat),
    .dp_wr_bkpt    (dp_wr_bkpt),
    .dp_bgnd_cmd   (dp_bgnd_cmd),
    .dp_mem_cmd    (dp_mem_cmd),
    .dp_wdata      (dp_wdata),
    .dp_stat       (dp_stat),
    .dp_bkpt       (dp_bkpt),
    .halt_req      (halt_req)
);

// File: tb/sim_dbg_halt_ctl.sv
// Bench for dbg_halt_ctl: directed sequences plus seeded random stimulus,
// every cycle compared with a model built from the requirements.
module sim_dbg_halt_ctl;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_bgnd = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic cpu_bus_vld = 0, cpu_fetch = 0, cpu_exec = 0, cpu_flush = 0, cpu_ibound = 0;
    logic cpu_wait_stop = 0, cpu_slow_busy = 0;
    logic dp_wr_ctl = 0, dp_rd_stat = 0, dp_wr_bkpt = 0, dp_bgnd_cmd = 0, dp_go = 0, dp_mem_cmd = 0;
    logic [AW-1:0] dp_wdata = '0;
    logic [7:0] dp_stat;
    logic [AW-1:0] dp_bkpt;
    logic halt_req;

    int checks = 0;
    int fails = 0;

    // model state
    logic [7:0]    m_s;
    logic [AW-1:0] m_bk;
    logic          m_fp, m_tp, m_halt;

    always #10 clk = ~clk;

    dbg_halt_ctl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .boot_bgnd(boot_bgnd), .cpu_addr(cpu_addr),
        .cpu_bus_vld(cpu_bus_vld), .cpu_fetch(cpu_fetch), .cpu_exec(cpu_exec),
        .cpu_flush(cpu_flush), .cpu_ibound(cpu_ibound), .cpu_wait_stop(cpu_wait_stop),
        .cpu_slow_busy(cpu_slow_busy), .dp_wr_ctl(dp_wr_ctl), .dp_rd_stat(dp_rd_stat),
        .dp_wr_bkpt(dp_wr_bkpt), .dp_bgnd_cmd(dp_bgnd_cmd), .dp_go(dp_go),
        .dp_mem_cmd(dp_mem_cmd), .dp_wdata(dp_wdata), .dp_stat(dp_stat),
        .dp_bkpt(dp_bkpt), .halt_req(halt_req)
    );

    function automatic logic [7:0] reset_word(input logic b);
        return {b, b, 2'b00, b, 3'b000};
    endfunction

    // Next model state from current model and inputs.
    task automatic model_next();
        logic en, act, bk, fm, mt, can, h, fon, ton;
        logic [7:0] s;
        en = m_s[7]; act = m_s[6]; bk = m_s[5]; fm = m_s[4];
        mt = (cpu_addr == m_bk);
        fon = bk & fm; ton = bk & ~fm;
        can = en & ~act;
        h = can & (dp_bgnd_cmd | (fon & m_fp & cpu_ibound) |
                   (ton & m_tp & cpu_exec & ~cpu_flush));
        s = m_s;
        if (dp_wr_ctl) begin
            s[7] = dp_wdata[7]; s[5] = dp_wdata[5]; s[4] = dp_wdata[4]; s[3] = dp_wdata[3];
        end
        s[6] = h | (act & ~dp_go);
        s[2] = cpu_wait_stop | (m_s[2] & ~dp_rd_stat);
        s[1] = (dp_mem_cmd & cpu_wait_stop) | (m_s[1] & ~dp_rd_stat);
        s[0] = (dp_mem_cmd & ~cpu_wait_stop & cpu_slow_busy) | (m_s[0] & ~dp_rd_stat);
        if (!fon || h)                   m_fp = 1'b0;
        else if (cpu_bus_vld && mt)      m_fp = 1'b1;
        if (cpu_flush || !ton || h)      m_tp = 1'b0;
        else if (cpu_fetch)              m_tp = mt;
        else if (cpu_exec)               m_tp = 1'b0;
        if (dp_wr_bkpt) m_bk = dp_wdata;
        m_halt = h;
        m_s = s;
    endtask

    task automatic clear_strobes();
        cpu_bus_vld = 0; cpu_fetch = 0; cpu_exec = 0; cpu_flush = 0; cpu_ibound = 0;
        cpu_wait_stop = 0; cpu_slow_busy = 0;
        dp_wr_ctl = 0; dp_rd_stat = 0; dp_wr_bkpt = 0; dp_bgnd_cmd = 0; dp_go = 0; dp_mem_cmd = 0;
    endtask

    // One clock: model update, edge, compare outputs, clear strobes.
    task automatic cyc(input string tag);
        model_next();
        @(posedge clk); #1;
        checks++;
        if (dp_stat !== m_s || halt_req !== m_halt || dp_bkpt !== m_bk) begin
            fails++;
            $display("FAIL %s: stat=%h halt=%b bkpt=%h expected stat=%h halt=%b bkpt=%h",
                     tag, dp_stat, halt_req, dp_bkpt, m_s, m_halt, m_bk);
        end
        clear_strobes();
    endtask

    task automatic expect_val(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    task automatic do_reset(input logic b);
        clear_strobes();
        boot_bgnd = b; rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        m_s = reset_word(b); m_bk = '0; m_fp = 0; m_tp = 0; m_halt = 0;
        expect_val("R1 reset word", {24'd0, dp_stat}, {24'd0, reset_word(b)});
        expect_val("R1 reset halt/bkpt", {15'd0, halt_req, dp_bkpt}, 32'd0);
        expect_val("R12 clock select", {31'd0, dp_stat[3]}, {31'd0, b});
    endtask

    task automatic wctl(input logic [7:0] v);
        dp_wr_ctl = 1; dp_wdata = {8'h00, v}; cyc("R2 ctl write");
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        do_reset(1'b0);

        // R2: write all ones; read-only bits stay clear
        wctl(8'hFF);
        expect_val("R2 writable bits", {24'd0, dp_stat}, 32'h0000_00B8);

        // R3: breakpoint write
        dp_wr_bkpt = 1; dp_wdata = 16'h1234; cyc("R3 bkpt write");
        expect_val("R3 bkpt readback", {16'd0, dp_bkpt}, 32'h0000_1234);

        // R4: forced stop at next boundary
        wctl(8'hB0);
        cpu_addr = 16'h1234; cpu_bus_vld = 1; cyc("R4 match");
        expect_val("R4 no halt at match", {31'd0, halt_req}, 32'd0);
        cpu_ibound = 1; cyc("R4 boundary");
        expect_val("R4 halt at boundary", {31'd0, halt_req}, 32'd1);
        expect_val("R4 active set", {31'd0, dp_stat[6]}, 32'd1);
        cyc("R4 pulse end");
        expect_val("R4 one-cycle pulse", {31'd0, halt_req}, 32'd0);

        // R9: no halt while active; go releases
        dp_bgnd_cmd = 1; cyc("R9 bgnd while active");
        expect_val("R9 no halt when active", {31'd0, halt_req}, 32'd0);
        dp_go = 1; cyc("R9 go");
        expect_val("R9 go clears active", {31'd0, dp_stat[6]}, 32'd0);

        // R5: mark and execute
        wctl(8'hA0);
        cpu_addr = 16'h1234; cpu_fetch = 1; cyc("R5 fetch");
        cpu_exec = 1; cyc("R5 exec");
        expect_val("R5 halt on marked exec", {31'd0, halt_req}, 32'd1);
        dp_go = 1; cyc("R5 go");
        cpu_addr = 16'h1233; cpu_fetch = 1; cyc("R5 other fetch");
        cpu_exec = 1; cyc("R5 other exec");
        expect_val("R5 no halt unmarked", {31'd0, halt_req}, 32'd0);

        // R6: flush discards; later fetch replaces
        cpu_addr = 16'h1234; cpu_fetch = 1; cyc("R6 fetch");
        cpu_flush = 1; cyc("R6 flush");
        cpu_exec = 1; cyc("R6 exec after flush");
        expect_val("R6 no halt after flush", {31'd0, halt_req}, 32'd0);
        cpu_addr = 16'h1234; cpu_fetch = 1; cyc("R6 fetch");
        cpu_addr = 16'h2000; cpu_fetch = 1; cyc("R6 refetch");
        cpu_exec = 1; cyc("R6 exec after refetch");
        expect_val("R6 no halt after refetch", {31'd0, halt_req}, 32'd0);

        // R7: breakpoint disabled
        wctl(8'h80);
        cpu_addr = 16'h1234; cpu_fetch = 1; cyc("R7 fetch");
        cpu_exec = 1; cyc("R7 exec");
        expect_val("R7 no tag halt", {31'd0, halt_req}, 32'd0);
        wctl(8'h90);
        cpu_addr = 16'h1234; cpu_bus_vld = 1; cyc("R7 match");
        cpu_ibound = 1; cyc("R7 boundary");
        expect_val("R7 no force halt", {31'd0, halt_req}, 32'd0);

        // R8: debug enable gating
        wctl(8'h30);
        cpu_addr = 16'h1234; cpu_bus_vld = 1; cyc("R8 match");
        cpu_ibound = 1; cyc("R8 boundary");
        expect_val("R8 no halt disabled", {31'd0, halt_req}, 32'd0);
        dp_bgnd_cmd = 1; cyc("R8 bgnd disabled");
        expect_val("R8 bgnd ignored", {31'd0, halt_req}, 32'd0);
        wctl(8'h80);
        dp_bgnd_cmd = 1; cyc("R8 bgnd enabled");
        expect_val("R8 bgnd halts", {31'd0, halt_req}, 32'd1);
        dp_go = 1; cyc("R8 go");

        // R10, R11: sticky flags
        cpu_wait_stop = 1; cyc("R10 wait seen");
        expect_val("R10 bit2 set", {29'd0, dp_stat[2:0]}, 32'd4);
        dp_rd_stat = 1; cyc("R10 read");
        expect_val("R10 read clears", {29'd0, dp_stat[2:0]}, 32'd0);
        dp_mem_cmd = 1; cpu_wait_stop = 1; cpu_slow_busy = 1; cyc("R11 both");
        expect_val("R11 wait has priority", {29'd0, dp_stat[2:0]}, 32'd6);
        dp_mem_cmd = 1; cpu_slow_busy = 1; dp_rd_stat = 1; cyc("R11 slow with read");
        expect_val("R10 set wins over read", {29'd0, dp_stat[2:0]}, 32'd1);
        dp_rd_stat = 1; cpu_wait_stop = 1; cyc("R10 read with wait");
        expect_val("R10 bit2 kept on read", {29'd0, dp_stat[2:0]}, 32'd4);
        dp_rd_stat = 1; cyc("R10 final read");

        // Random phase, model compared every cycle (R4 R5 R6 R9 R10 R11)
        for (int i = 0; i < 600; i++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            cpu_addr    = (r < 7) ? m_bk : (r < 10) ? m_bk + 16'd1 : 16'($urandom);
            cpu_bus_vld = ($urandom_range(0, 3) == 0);
            cpu_fetch   = ($urandom_range(0, 2) == 0);
            cpu_exec    = ($urandom_range(0, 2) == 0);
            cpu_flush   = ($urandom_range(0, 7) == 0);
            cpu_ibound  = ($urandom_range(0, 3) == 0);
            cpu_wait_stop = ($urandom_range(0, 7) == 0);
            cpu_slow_busy = ($urandom_range(0, 3) == 0);
            dp_mem_cmd  = ($urandom_range(0, 7) == 0);
            dp_rd_stat  = ($urandom_range(0, 7) == 0);
            dp_bgnd_cmd = ($urandom_range(0, 15) == 0);
            dp_go       = ($urandom_range(0, 5) == 0);
            dp_wr_ctl   = ($urandom_range(0, 19) == 0);
            dp_wr_bkpt  = ($urandom_range(0, 63) == 0);
            dp_wdata    = dp_wr_ctl ? {8'h00, 8'($urandom) | 8'hA0} : 16'($urandom);
            cyc("R5 R4 random model");
        end

        // R1, R12: reset into background mode
        do_reset(1'b1);
        expect_val("R1 boot word", {24'd0, dp_stat}, 32'h0000_00C8);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule